// File: doc/BRIEF.md
# Two-Stage Programmed-I/O Data Buffer

This block is the data buffer register that a disk controller exposes to the host bus for programmed I/O. It holds two word stages and two handshake flags: a ready-for-input flag and a ready-for-output flag. The host either writes a word into the buffer or reads a word out of it, and the flags let the two kinds of access alternate strictly.

An access made in the wrong state does not stall the bus. A write is made while the buffer is not ready for input, or a read is made while no word is ready for output. Either one is dropped and a sticky data-late error flag is raised. The three flags leave the block as plain outputs, so the controller can merge them into its second control/status register. A write to that register forces the input flag back on. A controller clear returns the whole block to its reset state.

The default variant shifts the stages. An accepted write moves the second stage into the first and puts the new word in the second. The parameter `WR_COPY` selects a variant that loads the new word into both stages instead.

Top module: `dbuf_pio`

## Requirements
- R1: After reset, `in_rdy`=1, `out_rdy`=0, `late_err`=0 and `rd_data`=0. Both stages are zero.
- R2: A write made while `in_rdy`=0 is discarded. In the next cycle `late_err`=1, and `rd_data`, `in_rdy` and `out_rdy` are unchanged.
- R3: An accepted write (`in_rdy`=1) copies the second stage into the first stage and stores `wr_data` in the second stage. `rd_data` always shows the first stage.
- R4: After an accepted write, `out_rdy`=1 and `in_rdy`=0 in the next cycle.
- R5: A read made while `out_rdy`=0 sets `late_err` in the next cycle. `rd_data`, `in_rdy` and `out_rdy` are unchanged.
- R6: During the cycle of an accepted read, `rd_data` holds the first stage. After the edge the first stage takes the second stage's word, `out_rdy`=0 and `in_rdy`=1.
- R7: A pulse on `cs2_wr` makes `in_rdy`=1 in the next cycle and leaves `out_rdy` as it was. This holds even when an accepted write happens in the same cycle.
- R8: `late_err` stays set until `ctl_clr` or reset. `ctl_clr` returns every flag and both stages to the R1 state and overrides any other access in the same cycle.
- R9: If a write and a read are both accepted in the same cycle, the stages shift with the new word as in R3. The write's flag result (`out_rdy`=1, `in_rdy`=0) wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_clr | input | 1 | Controller clear pulse |
| cs2_wr | input | 1 | Write strobe of the second control/status register |
| wr_stb | input | 1 | Bus write to the data buffer |
| wr_data | input | W | Word being written |
| rd_stb | input | 1 | Bus read of the data buffer |
| rd_data | output | W | First stage, the word a read returns |
| in_rdy | output | 1 | Buffer accepts a write |
| out_rdy | output | 1 | Buffer holds a word for reading |
| late_err | output | 1 | Sticky data-late error |

## Verification
The bench targets the states in which the handshake is easiest to get wrong. It makes a second write before any read, which a design without an overrun check would accept, overwriting the stage and setting the flags wrongly. It makes a second read after the buffer is drained, which a design without an underrun check would treat as a pop, shifting the stage and leaving `late_err` clear. It checks the one-word lag of the shifting stages, where a design that loads the first stage directly returns the wrong word. It also drives precedence collisions: a control/status write or a controller clear in the same cycle as a data access, and a simultaneous accepted read and write. A wrong priority order there leaves the input flag or the error flag in the wrong state.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
   typedef struct packed {
      logic in_rdy;
      logic out_rdy;
      logic late;
   } dbuf_flags_t;

   localparam dbuf_flags_t DBUF_FLAGS_RST = '{in_rdy: 1'b1, out_rdy: 1'b0, late: 1'b0};
endpackage

// File: rtl/dbuf_access.sv
module dbuf_access (
   input  logic wr_stb,
   input  logic rd_stb,
   input  logic in_rdy,
   input  logic out_rdy,
   output logic wr_ok,
   output logic rd_ok,
   output logic late_hit
);
   always_comb begin
      wr_ok    = wr_stb & in_rdy;
      rd_ok    = rd_stb & out_rdy;
      late_hit = (wr_stb & ~in_rdy) | (rd_stb & ~out_rdy);
   end
endmodule

// File: rtl/dbuf_flags.sv
module dbuf_flags
   import dbuf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctl_clr,
   input  logic        cs2_wr,
   input  logic        wr_ok,
   input  logic        rd_ok,
   input  logic        late_hit,
   output dbuf_flags_t flags
);
   dbuf_flags_t nxt;

   always_comb begin
      nxt = flags;
      if (late_hit)
         nxt.late = 1'b1;
      if (wr_ok) begin
         nxt.in_rdy  = 1'b0;
         nxt.out_rdy = 1'b1;
      end else if (rd_ok) begin
         nxt.in_rdy  = 1'b1;
         nxt.out_rdy = 1'b0;
      end
      if (cs2_wr)
         nxt.in_rdy = 1'b1;
      if (ctl_clr)
         nxt = DBUF_FLAGS_RST;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags <= DBUF_FLAGS_RST;
      else
         flags <= nxt;
   end
endmodule

// File: rtl/dbuf_stages.sv
module dbuf_stages #(
   parameter int W       = 16,
   parameter bit WR_COPY = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ctl_clr,
   input  logic         wr_ok,
   input  logic         rd_ok,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] stage0
);
   logic [W-1:0] stage1;
   logic [W-1:0] s0_wr;

   generate
      if (WR_COPY) begin : g_copy
         assign s0_wr = wr_data;
      end else begin : g_shift
         assign s0_wr = stage1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage0 <= '0;
         stage1 <= '0;
      end else if (ctl_clr) begin
         stage0 <= '0;
         stage1 <= '0;
      end else if (wr_ok) begin
         stage0 <= s0_wr;
         stage1 <= wr_data;
      end else if (rd_ok) begin
         stage0 <= stage1;
      end
   end
endmodule

// File: rtl/dbuf_pio.sv
module dbuf_pio
   import dbuf_pkg::*;
#(
   parameter int W       = 16,
   parameter bit WR_COPY = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ctl_clr,
   input  logic         cs2_wr,
   input  logic         wr_stb,
   input  logic [W-1:0] wr_data,
   input  logic         rd_stb,
   output logic [W-1:0] rd_data,
   output logic         in_rdy,
   output logic         out_rdy,
   output logic         late_err
);
   generate
      if (W < 1) begin : g_bad_width
         $error("dbuf_pio: W must be at least 1");
      end
   endgenerate

   dbuf_flags_t flags;
   logic        wr_ok, rd_ok, late_hit;

   dbuf_access u_acc (
      .wr_stb  (wr_stb),
      .rd_stb  (rd_stb),
      .in_rdy  (flags.in_rdy),
      .out_rdy (flags.out_rdy),
      .wr_ok   (wr_ok),
      .rd_ok   (rd_ok),
      .late_hit(late_hit)
   );

   dbuf_flags u_flg (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_clr (ctl_clr),
      .cs2_wr  (cs2_wr),
      .wr_ok   (wr_ok),
      .rd_ok   (rd_ok),
      .late_hit(late_hit),
      .flags   (flags)
   );

   dbuf_stages #(.W(W), .WR_COPY(WR_COPY)) u_stg (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl_clr(ctl_clr),
      .wr_ok  (wr_ok),
      .rd_ok  (rd_ok),
      .wr_data(wr_data),
      .stage0 (rd_data)
   );

   assign in_rdy   = flags.in_rdy;
   assign out_rdy  = flags.out_rdy;
   assign late_err = flags.late;
endmodule

// File: rtl/dbuf_chk.sv
module dbuf_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         ctl_clr,
   input logic         cs2_wr,
   input logic         wr_stb,
   input logic         rd_stb,
   input logic [W-1:0] rd_data,
   input logic         in_rdy,
   input logic         out_rdy,
   input logic         late_err
);
   p_overrun_late_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !in_rdy && !ctl_clr) |=> late_err);

   p_overrun_keeps_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !in_rdy && !rd_stb && !ctl_clr) |=> $stable(rd_data));

   p_write_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && in_rdy && !cs2_wr && !ctl_clr) |=> (out_rdy && !in_rdy));

   p_underrun_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !out_rdy && !ctl_clr) |=> late_err);

   p_underrun_keeps_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !out_rdy && !wr_stb && !ctl_clr) |=> $stable(rd_data));

   p_read_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && out_rdy && !wr_stb && !ctl_clr) |=> (in_rdy && !out_rdy));

   p_cs2_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cs2_wr && !ctl_clr) |=> in_rdy);

   p_late_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (late_err && !ctl_clr) |=> late_err);

   p_clear_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_clr |=> (in_rdy && !out_rdy && !late_err && rd_data == '0));
endmodule

bind dbuf_pio dbuf_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ctl_clr (ctl_clr),
   .cs2_wr  (cs2_wr),
   .wr_stb  (wr_stb),
   .rd_stb  (rd_stb),
   .rd_data (rd_data),
   .in_rdy  (in_rdy),
   .out_rdy (out_rdy),
   .late_err(late_err)
);

// File: tb/sim_dbuf_pio.sv
module sim_dbuf_pio;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ctl_clr = 1'b0, cs2_wr = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic         in_rdy, out_rdy, late_err;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbuf_pio #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .ctl_clr(ctl_clr), .cs2_wr(cs2_wr),
      .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
      .rd_data(rd_data), .in_rdy(in_rdy), .out_rdy(out_rdy), .late_err(late_err)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_st(input string tag, input logic ir, input logic orr,
                         input logic dl, input logic [W-1:0] d);
      chk({tag, " in_rdy"},  {{(W-1){1'b0}}, in_rdy},   {{(W-1){1'b0}}, ir});
      chk({tag, " out_rdy"}, {{(W-1){1'b0}}, out_rdy},  {{(W-1){1'b0}}, orr});
      chk({tag, " late"},    {{(W-1){1'b0}}, late_err}, {{(W-1){1'b0}}, dl});
      chk({tag, " data"},    rd_data, d);
   endtask

   // One access cycle: drive at negedge, edge at posedge, release after it.
   task automatic step(input logic w, input logic [W-1:0] wd, input logic r,
                       input logic c2, input logic cl);
      @(negedge clk);
      wr_stb = w; wr_data = wd; rd_stb = r; cs2_wr = c2; ctl_clr = cl;
      @(posedge clk);
      #1;
      wr_stb = 0; rd_stb = 0; cs2_wr = 0; ctl_clr = 0;
      #1;
   endtask

   task automatic t_reset;
      chk_st("R1 reset", 1, 0, 0, 16'h0000);
   endtask

   task automatic t_write_read;
      step(1, 16'h1234, 0, 0, 0);
      chk_st("R3 R4 first write", 0, 1, 0, 16'h0000);
      @(negedge clk);
      rd_stb = 1;
      #1 chk("R6 data during read", rd_data, 16'h0000);
      @(posedge clk); #1 rd_stb = 0; #1;
      chk_st("R6 after read", 1, 0, 0, 16'h1234);
      step(1, 16'h5678, 0, 0, 0);
      chk_st("R3 shifted write", 0, 1, 0, 16'h1234);
      step(0, '0, 1, 0, 0);
      chk_st("R6 second read", 1, 0, 0, 16'h5678);
   endtask

   task automatic t_overrun;
      step(1, 16'hAAAA, 0, 0, 0);
      chk_st("R4 write ok", 0, 1, 0, 16'h5678);
      step(1, 16'hBBBB, 0, 0, 0);
      chk_st("R2 overrun", 0, 1, 1, 16'h5678);
      step(0, '0, 1, 0, 0);
      chk_st("R8 late sticky after read", 1, 0, 1, 16'hAAAA);
      step(0, '0, 0, 0, 1);
      chk_st("R8 clear", 1, 0, 0, 16'h0000);
   endtask

   task automatic t_underrun;
      step(1, 16'h0011, 0, 0, 0);
      step(0, '0, 1, 0, 0);
      chk_st("R6 read", 1, 0, 0, 16'h0011);
      step(0, '0, 1, 0, 0);
      chk_st("R5 underrun", 1, 0, 1, 16'h0011);
      step(0, '0, 0, 0, 1);
      chk_st("R8 clear after underrun", 1, 0, 0, 16'h0000);
   endtask

   task automatic t_collide;
      step(1, 16'h0022, 0, 0, 0);
      chk_st("R4 write", 0, 1, 0, 16'h0000);
      step(0, '0, 0, 1, 0);
      chk_st("R7 cs2 forces input", 1, 1, 0, 16'h0000);
      step(1, 16'h0033, 1, 0, 0);
      chk_st("R9 write and read together", 0, 1, 0, 16'h0022);
      step(0, '0, 0, 1, 0);
      step(1, 16'h0044, 0, 1, 0);
      chk_st("R7 cs2 beats write", 1, 1, 0, 16'h0033);
      step(1, 16'h0055, 0, 0, 1);
      chk_st("R8 clear beats write", 1, 0, 0, 16'h0000);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 5000);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 2 + 3);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_write_read();
      t_overrun();
      t_underrun();
      t_collide();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule